// File: doc/BRIEF.md
# Accumulator ALU with Carry and Status Flags

This block is the arithmetic and logic stage of a small accumulator processor. Each cycle it takes an operation code, the accumulator value and a second operand, which may come from data memory or an immediate field. It returns a result of the same width and a strobe that says whether the result is to be written back. The block owns the two flag registers, carry (CF) and status (SF), and updates them on the clock edge that ends each valid operation.

SF has no single meaning. Depending on the operation it holds the inverted carry, the carry itself, a not-zero indication, an inverted bit, or a constant one. The flag instructions also let the block decide conditional branches: a branch operation is taken only while SF is set. CF changes only on add-with-carry, reverse subtract and the explicit clear and set operations. Every other operation leaves it alone. All arithmetic wraps at the operand width.

Operation codes (4 bits): 0 load, 1 add, 2 add with carry, 3 reverse subtract, 4 increment, 5 decrement, 6 AND, 7 OR, 8 XOR, 9 bit test, 10 carry test, 11 clear carry, 12 set carry, 13 branch, 14 and 15 reserved.

Top module: `acc_alu`

## Requirements
- R1: While reset is asserted, and right after it is released, CF is 0 and SF is 1.
- R2: Add (code 1) returns (acc+opnd) mod 2^W. Increment (code 4) returns (opnd+1) mod 2^W. Both write the result, set SF to the inverse of the carry out of the top bit, and leave CF unchanged.
- R3: Add with carry (code 2) returns (acc+opnd+CF) mod 2^W and writes the result. CF takes the carry out and SF takes its inverse.
- R4: Reverse subtract (code 3) returns (opnd-acc-(1-CF)) mod 2^W and writes the result. CF becomes 1 exactly when no borrow occurred, and SF equals the new CF.
- R5: Decrement (code 5) returns (opnd-1) mod 2^W and writes the result. SF is 1 unless opnd was 0 (the wrap case), and CF is unchanged.
- R6: AND, OR and XOR (codes 6, 7, 8) combine acc with opnd and write the result. SF is 1 when the result is nonzero and 0 when it is zero, and CF is unchanged.
- R7: Load (code 0) passes opnd to the result and writes it. SF becomes 1 and CF is unchanged.
- R8: Bit test (code 9) sets SF to the inverse of opnd[bit_sel]. It writes no result and leaves CF unchanged.
- R9: Carry test (code 10) copies CF into SF, writes no result and leaves CF unchanged.
- R10: Clear carry (code 11) makes CF 0 and set carry (code 12) makes CF 1. Both make SF 1 and write no result.
- R11: Branch (code 13) raises branch_take in the same cycle exactly when SF is 1. It writes no result, leaves CF unchanged and makes SF 1 afterwards.
- R12: When op_valid is low, or the code is 14 or 15, res_we and branch_take are 0 and both flags hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | An operation is presented this cycle |
| op | input | 4 | Operation code |
| acc_in | input | W | Accumulator operand |
| opnd_in | input | W | Memory or immediate operand |
| bit_sel | input | max(1,clog2(W)) | Bit index for the bit test |
| res | output | W | Result |
| res_we | output | 1 | Result is to be written back |
| branch_take | output | 1 | Conditional branch is taken |
| cf | output | 1 | Carry flag register |
| sf | output | 1 | Status flag register |

## Verification
The bench uses the default width W=4. At that width the full 16 by 16 operand space of every arithmetic and logic operation can be swept with CF both clear and set. This covers every carry-out and borrow boundary, including the decrement wrap from 0 and the reverse subtract with equal operands. The zero result of each logic operation and every bit position of the bit test are also reached. Branches are issued with SF forced both low and high, which shows the branch condition and the SF value the branch leaves behind.

// File: rtl/acc_alu.sv
module acc_alu #(
  parameter int W = 4,
  localparam int BW = (W > 1) ? $clog2(W) : 1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          op_valid,
  input  logic [3:0]    op,
  input  logic [W-1:0]  acc_in,
  input  logic [W-1:0]  opnd_in,
  input  logic [BW-1:0] bit_sel,
  output logic [W-1:0]  res,
  output logic          res_we,
  output logic          branch_take,
  output logic          cf,
  output logic          sf
);

  localparam logic [3:0] OP_LOAD = 4'd0;
  localparam logic [3:0] OP_ADD  = 4'd1;
  localparam logic [3:0] OP_ADDC = 4'd2;
  localparam logic [3:0] OP_SUBR = 4'd3;
  localparam logic [3:0] OP_INC  = 4'd4;
  localparam logic [3:0] OP_DEC  = 4'd5;
  localparam logic [3:0] OP_AND  = 4'd6;
  localparam logic [3:0] OP_OR   = 4'd7;
  localparam logic [3:0] OP_XOR  = 4'd8;
  localparam logic [3:0] OP_TBIT = 4'd9;
  localparam logic [3:0] OP_TCF  = 4'd10;
  localparam logic [3:0] OP_CLRC = 4'd11;
  localparam logic [3:0] OP_SETC = 4'd12;
  localparam logic [3:0] OP_JMP  = 4'd13;

  logic [W:0]   sum;
  logic [W:0]   cin;
  logic [W-1:0] res_n;
  logic         we_n, cf_n, sf_n;

  assign cin = {{W{1'b0}}, cf};

  always_comb begin
    sum   = '0;
    res_n = opnd_in;
    we_n  = 1'b0;
    cf_n  = cf;
    sf_n  = sf;
    unique case (op)
      OP_LOAD: begin we_n = 1'b1; sf_n = 1'b1; end
      OP_ADD: begin
        sum = {1'b0, acc_in} + {1'b0, opnd_in};
        res_n = sum[W-1:0]; we_n = 1'b1; sf_n = ~sum[W];
      end
      OP_ADDC: begin
        sum = {1'b0, acc_in} + {1'b0, opnd_in} + cin;
        res_n = sum[W-1:0]; we_n = 1'b1; cf_n = sum[W]; sf_n = ~sum[W];
      end
      OP_SUBR: begin
        sum = {1'b0, opnd_in} + {1'b0, ~acc_in} + cin;
        res_n = sum[W-1:0]; we_n = 1'b1; cf_n = sum[W]; sf_n = sum[W];
      end
      OP_INC: begin
        sum = {1'b0, opnd_in} + {{W{1'b0}}, 1'b1};
        res_n = sum[W-1:0]; we_n = 1'b1; sf_n = ~sum[W];
      end
      OP_DEC: begin
        sum = {1'b0, opnd_in} + {1'b0, {W{1'b1}}};
        res_n = sum[W-1:0]; we_n = 1'b1; sf_n = sum[W];
      end
      OP_AND: begin res_n = acc_in & opnd_in; we_n = 1'b1; sf_n = |res_n; end
      OP_OR:  begin res_n = acc_in | opnd_in; we_n = 1'b1; sf_n = |res_n; end
      OP_XOR: begin res_n = acc_in ^ opnd_in; we_n = 1'b1; sf_n = |res_n; end
      OP_TBIT: sf_n = ~opnd_in[bit_sel];
      OP_TCF:  sf_n = cf;
      OP_CLRC: begin cf_n = 1'b0; sf_n = 1'b1; end
      OP_SETC: begin cf_n = 1'b1; sf_n = 1'b1; end
      OP_JMP:  sf_n = 1'b1;
      default: ;
    endcase
  end

  assign res         = res_n;
  assign res_we      = op_valid & we_n;
  assign branch_take = op_valid & (op == OP_JMP) & sf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cf <= 1'b0;
      sf <= 1'b1;
    end else if (op_valid) begin
      cf <= cf_n;
      sf <= sf_n;
    end
  end

  a_r12_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |=> $stable(cf) && $stable(sf));

  a_r12_reserved_hold: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op >= 4'd14 |=> $stable(cf) && $stable(sf));

  a_r3_sf_inverts_cf: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_ADDC |=> sf == !cf);

  a_r4_sf_equals_cf: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_SUBR |=> sf == cf);

  a_r9_cf_copied: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_TCF |=> sf == $past(cf) && $stable(cf));

  a_r10_flag_write: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && (op == OP_CLRC || op == OP_SETC) |=> sf && cf == $past(op == OP_SETC));

  a_r11_branch_sets_sf: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op == OP_JMP |=> sf && $stable(cf));

  a_r8_no_writeback: assert property (@(posedge clk) disable iff (!rst_n)
    op_valid && op >= OP_TBIT |-> !res_we);

endmodule

// File: tb/acc_alu_tb.sv
module acc_alu_tb;
  localparam int W = 4;
  localparam int BW = (W > 1) ? $clog2(W) : 1;
  localparam int M = 1 << W;
  localparam time PERIOD = 10;

  logic clk = 0, rst_n = 0, op_valid = 0;
  logic [3:0] op = '0;
  logic [W-1:0] acc_in = '0, opnd_in = '0;
  logic [BW-1:0] bit_sel = '0;
  logic [W-1:0] res;
  logic res_we, branch_take, cf, sf;

  acc_alu #(.W(W)) u_dut (.*);

  always #(PERIOD/2) clk = ~clk;

  typedef struct packed {
    logic [W-1:0] res;
    logic we, take, cf, sf;
    logic [7:0] req;
  } item_t;

  item_t q[$];
  int checks = 0, errors = 0;
  logic mcf = 0, msf = 1;
  bit finished = 0;

  task automatic chk(input bit ok, input int req, input string what, input int got, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL R%0d %s: actual %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic item_t model(input logic v, input logic [3:0] o, input int a, input int b,
                                  input int bs, input logic c, input logic s, input int req);
    item_t e;
    int t;
    e.res = '0; e.we = 0; e.take = 0; e.cf = c; e.sf = s; e.req = 8'(req);
    if (!v) return e;
    case (o)
      0: begin e.res = W'(b); e.we = 1; e.sf = 1; end
      1: begin t = a + b; e.res = W'(t % M); e.we = 1; e.sf = (t < M); end
      2: begin t = a + b + int'(c); e.res = W'(t % M); e.we = 1; e.cf = (t >= M); e.sf = (t < M); end
      3: begin t = b - a - (1 - int'(c)); e.res = W'((t + M) % M); e.we = 1; e.cf = (t >= 0); e.sf = (t >= 0); end
      4: begin t = b + 1; e.res = W'(t % M); e.we = 1; e.sf = (t < M); end
      5: begin e.res = W'((b + M - 1) % M); e.we = 1; e.sf = (b != 0); end
      6: begin e.res = W'(a & b); e.we = 1; e.sf = ((a & b) != 0); end
      7: begin e.res = W'(a | b); e.we = 1; e.sf = ((a | b) != 0); end
      8: begin e.res = W'(a ^ b); e.we = 1; e.sf = ((a ^ b) != 0); end
      9: e.sf = !((b >> bs) & 1);
      10: e.sf = c;
      11: begin e.cf = 0; e.sf = 1; end
      12: begin e.cf = 1; e.sf = 1; end
      13: begin e.take = s; e.sf = 1; end
      default: ;
    endcase
    return e;
  endfunction

  task automatic drive(input logic v, input logic [3:0] o, input int a, input int b, input int bs, input int req);
    item_t e;
    @(negedge clk);
    op_valid = v; op = o; acc_in = W'(a); opnd_in = W'(b); bit_sel = BW'(bs);
    e = model(v, o, a, b, bs, mcf, msf, req);
    q.push_back(e);
    mcf = e.cf; msf = e.sf;
  endtask

  // Monitor: combinational outputs checked in the cycle driven, flags one cycle later
  initial begin
    item_t cur, pend;
    bit have_pend = 0;
    forever begin
      @(negedge clk);
      #2;
      if (have_pend) begin
        chk(cf === pend.cf, int'(pend.req), "cf", int'(cf), int'(pend.cf));
        chk(sf === pend.sf, int'(pend.req), "sf", int'(sf), int'(pend.sf));
        have_pend = 0;
      end
      if (q.size() > 0) begin
        cur = q.pop_front();
        chk(res_we === cur.we, int'(cur.req), "res_we", int'(res_we), int'(cur.we));
        chk(branch_take === cur.take, int'(cur.req), "branch_take", int'(branch_take), int'(cur.take));
        if (cur.we) chk(res === cur.res, int'(cur.req), "res", int'(res), int'(cur.res));
        pend = cur; have_pend = 1;
      end
    end
  end

  initial begin
    #(PERIOD * 200000);
    if (!finished) begin
      errors++;
      $display("FAIL watchdog expired: actual running expected done");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    // R1: flags during and after reset
    repeat (2) @(negedge clk);
    #2;
    chk(cf === 1'b0 && sf === 1'b1, 1, "flags in reset", int'({cf, sf}), 1);
    chk(res_we === 1'b0, 12, "res_we idle", int'(res_we), 0);
    @(negedge clk); rst_n = 1;
    #2;
    chk(cf === 1'b0 && sf === 1'b1, 1, "flags after reset", int'({cf, sf}), 1);

    for (int c = 0; c < 2; c++) begin
      drive(1, (c == 0) ? 4'd11 : 4'd12, 0, 0, 0, 10);   // R10
      for (int a = 0; a < M; a++)
        for (int b = 0; b < M; b++) begin
          drive(1, 4'd1, a, b, 0, 2);                   // R2 add
          drive(1, 4'd4, a, b, 0, 2);                   // R2 increment
          drive(1, 4'd5, a, b, 0, 5);                   // R5
          drive(1, 4'd6, a, b, 0, 6);                   // R6
          drive(1, 4'd7, a, b, 0, 6);
          drive(1, 4'd8, a, b, 0, 6);
          drive(1, 4'd0, a, b, 0, 7);                   // R7
          drive(1, (c == 0) ? 4'd11 : 4'd12, 0, 0, 0, 10);
          drive(1, 4'd2, a, b, 0, 3);                   // R3
          drive(1, (c == 0) ? 4'd11 : 4'd12, 0, 0, 0, 10);
          drive(1, 4'd3, a, b, 0, 4);                   // R4
          drive(1, 4'd10, 0, 0, 0, 9);                  // R9
        end
    end

    for (int b = 0; b < M; b++)
      for (int bs = 0; bs < W; bs++) begin
        drive(1, 4'd9, 0, b, bs, 8);                    // R8
        drive(1, 4'd13, 0, 0, 0, 11);                   // R11 take follows SF
      end

    drive(1, 4'd12, 0, 0, 0, 10);
    drive(1, 4'd9, 0, 1, 0, 8);                         // SF low
    drive(1, 4'd13, 0, 0, 0, 11);                       // R11 not taken
    drive(1, 4'd13, 0, 0, 0, 11);                       // R11 taken
    drive(1, 4'd9, 0, 1, 0, 8);
    drive(0, 4'd13, 5, 5, 0, 12);                       // R12 invalid branch
    drive(1, 4'd14, 3, 3, 0, 12);                       // R12 reserved
    drive(1, 4'd15, 3, 3, 0, 12);
    drive(0, 4'd1, 15, 15, 0, 12);
    drive(0, 4'd0, 0, 0, 0, 12);
    drive(0, 4'd0, 0, 0, 0, 12);

    repeat (4) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule